// File: doc/BRIEF.md
# Buffered 16-bit Compare Channel

This block is one compare channel of a 16-bit timer. Software loads a 16-bit compare value over an 8-bit register bus. A shared high-byte staging register makes the two bytes of the value take effect together. Every clock, the block compares the active compare value with an external counter. On equality it gives a match pulse to the counter logic, raises a sticky interrupt flag, and updates an output pin according to a 2-bit output mode.

The counter, its TOP/BOTTOM detection and the waveform-mode decode are outside this block; they arrive as inputs. When `pwm_mode` is high, software writes land in a shadow buffer. The shadow is copied into the active value only at the selected end of the count sequence, so a PWM period never sees a half-changed threshold. When `pwm_mode` is low, writes go straight to the active value. In non-PWM modes a force strobe moves the pin as a real match would, without touching the flag or the match pulse.

Top module: `ocmp_channel`

## Requirements
- R1: While reset is applied and on release, the active value, shadow, staging byte, flag and pin are all zero, so both read addresses return 0x00 and `oc_pin` is low.
- R2: A write with `wr_hi`=1 only loads the staging byte; the value read back at either address and the value compared against `cnt` are unchanged.
- R3: A write with `wr_hi`=0 stores `{staging, wr_data}` into the target in one clock. The staging byte keeps its value, so a later low-only write reuses the earlier high byte.
- R4: With `pwm_mode`=0 the target is the active value. Reads (`rd_hi`=1 gives bits 15:8, `rd_hi`=0 gives bits 7:0) return the active value, and the new value is compared from the next cycle.
- R5: With `pwm_mode`=1 the target and the read source are the shadow. The active value takes the shadow only on a clock where `at_top`=1 (if `upd_at_top`=1) or `at_bottom`=1 (if `upd_at_top`=0). The strobe that is not selected has no effect.
- R6: `match_pulse` is high in the same cycle whenever all 16 bits of `cnt` equal the active value, and `match_flag` is high from the next cycle.
- R7: `flag_clr`=1 clears `match_flag` on the next clock, unless a match occurs in the same cycle, in which case the flag stays set.
- R8: `om_mode` sets the pin action on the clock after an event: 00 holds the pin low, 01 toggles it, 10 clears it, 11 sets it.
- R9: With `pwm_mode`=0, `force_cmp`=1 updates `oc_pin` exactly as a match would under `om_mode`. It neither asserts `match_pulse` nor sets `match_flag`.
- R10: With `pwm_mode`=1, `force_cmp` is ignored: without a match the pin keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_hi | input | 1 | Write address: 1 = high byte (staging), 0 = low byte |
| wr_data | input | 8 | Write data |
| rd_hi | input | 1 | Read address: 1 = bits 15:8, 0 = bits 7:0 |
| rd_data | output | 8 | Read data of the software-visible register |
| cnt | input | 16 | Timer counter value |
| at_top | input | 1 | Counter is at TOP this cycle |
| at_bottom | input | 1 | Counter is at BOTTOM this cycle |
| pwm_mode | input | 1 | A PWM mode is active (buffering on) |
| upd_at_top | input | 1 | 1 = shadow copy at TOP, 0 = at BOTTOM |
| om_mode | input | 2 | Pin action: 00 off, 01 toggle, 10 clear, 11 set |
| force_cmp | input | 1 | Force-compare strobe |
| flag_clr | input | 1 | Write-one-to-clear for the flag |
| match_pulse | output | 1 | Real compare match this cycle (for counter clear) |
| match_flag | output | 1 | Sticky compare interrupt flag |
| oc_pin | output | 1 | Compare output pin |

## Verification
A corrupted staging byte or a wrong write target shows on `rd_data` in the cycle right after the low-byte write. A premature or missed shadow copy shows as a `match_pulse` that appears or stays absent when `cnt` is driven to the old or the new value, within one cycle of the strobe. Faults in the flag or pin logic show on `match_flag` or `oc_pin` one clock after the triggering event. A mirrored reference model is compared on every clock, so these faults surface in the first cycle where they matter.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    OM_OFF    = 2'b00,
    OM_TOGGLE = 2'b01,
    OM_CLEAR  = 2'b10,
    OM_SET    = 2'b11
  } om_mode_e;
endpackage

// File: rtl/ocmp_rst_sync.sv
module ocmp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ocmp_regfile.sv
module ocmp_regfile #(
  parameter int unsigned BYTE_W = ocmp_pkg::BYTE_W,
  localparam int unsigned CMP_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_hi,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              pwm_mode,
  input  logic              upd_at_top,
  input  logic              at_top,
  input  logic              at_bottom,
  output logic [CMP_W-1:0]  cmp_val
);
  logic [BYTE_W-1:0] stage_q, stage_d;
  logic [CMP_W-1:0]  shad_q, shad_d;
  logic [CMP_W-1:0]  act_q, act_d;
  logic [CMP_W-1:0]  wr_word;
  logic              stage_en, shad_en, act_en;
  logic              lo_wr, upd_evt;
  logic [CMP_W-1:0]  vis;

  assign lo_wr   = wr_en & ~wr_hi;
  assign wr_word = {stage_q, wr_data};
  assign upd_evt = upd_at_top ? at_top : at_bottom;

  always_comb begin
    stage_en = wr_en & wr_hi;
    stage_d  = wr_data;
    shad_en  = lo_wr & pwm_mode;
    shad_d   = wr_word;
    act_en   = pwm_mode ? upd_evt : lo_wr;
    act_d    = pwm_mode ? shad_q : wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      shad_q  <= '0;
      act_q   <= '0;
    end else begin
      if (stage_en) stage_q <= stage_d;
      if (shad_en)  shad_q  <= shad_d;
      if (act_en)   act_q   <= act_d;
    end
  end

  assign vis     = pwm_mode ? shad_q : act_q;
  assign rd_data = rd_hi ? vis[CMP_W-1:BYTE_W] : vis[BYTE_W-1:0];
  assign cmp_val = act_q;

  // R2
  hi_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hi && !pwm_mode) |=> $stable(act_q));
  // R3
  lo_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hi && !pwm_mode) |=> (act_q[BYTE_W-1:0] == $past(wr_data)));
  // R5
  pwm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && !(upd_at_top ? at_top : at_bottom)) |=> $stable(act_q));
endmodule

// File: rtl/ocmp_match.sv
module ocmp_match #(
  parameter int unsigned CMP_W = 2 * ocmp_pkg::BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMP_W-1:0] cnt,
  input  logic [CMP_W-1:0] cmp_val,
  input  logic             flag_clr,
  output logic             hit,
  output logic             flag_q
);
  logic flag_d;

  assign hit = (cnt == cmp_val);

  always_comb begin
    flag_d = flag_q;
    if (flag_clr) flag_d = 1'b0;
    if (hit)      flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  // R6
  hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);
  // R7
  clr_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !hit) |=> !flag_q);
endmodule

// File: rtl/ocmp_pin.sv
module ocmp_pin (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  logic       force_cmp,
  input  logic       pwm_mode,
  input  logic [1:0] om_mode,
  output logic       pin_q
);
  import ocmp_pkg::*;

  logic     pin_d, evt;
  om_mode_e mode;

  assign mode = om_mode_e'(om_mode);
  assign evt  = hit | (force_cmp & ~pwm_mode);

  always_comb begin
    pin_d = pin_q;
    unique case (mode)
      OM_OFF:    pin_d = 1'b0;
      OM_TOGGLE: if (evt) pin_d = ~pin_q;
      OM_CLEAR:  if (evt) pin_d = 1'b0;
      OM_SET:    if (evt) pin_d = 1'b1;
      default:   pin_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  // R8
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (om_mode == 2'b00) |=> !pin_q);
  // R9
  force_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_cmp && !pwm_mode && om_mode == 2'b11) |=> pin_q);
  // R10
  pwm_force_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && !hit && om_mode != 2'b00) |=> $stable(pin_q));
endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel #(
  parameter int unsigned BYTE_W = ocmp_pkg::BYTE_W,
  localparam int unsigned CMP_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_hi,
  output logic [BYTE_W-1:0] rd_data,
  input  logic [CMP_W-1:0]  cnt,
  input  logic              at_top,
  input  logic              at_bottom,
  input  logic              pwm_mode,
  input  logic              upd_at_top,
  input  logic [1:0]        om_mode,
  input  logic              force_cmp,
  input  logic              flag_clr,
  output logic              match_pulse,
  output logic              match_flag,
  output logic              oc_pin
);
  logic             rst_i_n;
  logic [CMP_W-1:0] cmp_val;
  logic             hit;

  ocmp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  ocmp_regfile #(.BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .wr_en(wr_en), .wr_hi(wr_hi),
    .wr_data(wr_data), .rd_hi(rd_hi), .rd_data(rd_data),
    .pwm_mode(pwm_mode), .upd_at_top(upd_at_top), .at_top(at_top),
    .at_bottom(at_bottom), .cmp_val(cmp_val)
  );

  ocmp_match #(.CMP_W(CMP_W)) u_match (
    .clk(clk), .rst_n(rst_i_n), .cnt(cnt), .cmp_val(cmp_val),
    .flag_clr(flag_clr), .hit(hit), .flag_q(match_flag)
  );

  ocmp_pin u_pin (
    .clk(clk), .rst_n(rst_i_n), .hit(hit), .force_cmp(force_cmp),
    .pwm_mode(pwm_mode), .om_mode(om_mode), .pin_q(oc_pin)
  );

  assign match_pulse = hit;

  // R6
  pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    match_pulse |=> match_flag);
endmodule

// File: tb/test_ocmp_channel.sv
module test_ocmp_channel;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, wr_hi, rd_hi, at_top, at_bottom, pwm_mode, upd_at_top;
  logic force_cmp, flag_clr;
  logic [7:0]  wr_data, rd_data;
  logic [15:0] cnt;
  logic [1:0]  om_mode;
  logic match_pulse, match_flag, oc_pin;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0]  m_stage;
  logic [15:0] m_shad, m_act;
  logic        m_flag, m_pin;

  always #(CLK_PERIOD/2) clk = ~clk;

  ocmp_channel i_ocmp_channel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data),
    .rd_hi(rd_hi), .rd_data(rd_data), .cnt(cnt), .at_top(at_top),
    .at_bottom(at_bottom), .pwm_mode(pwm_mode), .upd_at_top(upd_at_top),
    .om_mode(om_mode), .force_cmp(force_cmp), .flag_clr(flag_clr),
    .match_pulse(match_pulse), .match_flag(match_flag), .oc_pin(oc_pin)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic pin_after(logic cur, logic ev, logic [1:0] m);
    if (m == 2'b00) return 1'b0;
    if (!ev) return cur;
    if (m == 2'b01) return ~cur;
    return (m == 2'b11);
  endfunction

  function automatic logic [15:0] visible(logic pw);
    return pw ? m_shad : m_act;
  endfunction

  // One clock: drive at negedge, check, advance model at the edge.
  task automatic step(bit we, bit hi, logic [7:0] d, bit rh, logic [15:0] c,
                      bit t, bit b, bit pw, bit ut, logic [1:0] m, bit f, bit fc);
    logic [15:0] vis, nshad, nact;
    logic [7:0]  nstage;
    logic        hitm, nflag, npin;
    wr_en = we; wr_hi = hi; wr_data = d; rd_hi = rh; cnt = c; at_top = t;
    at_bottom = b; pwm_mode = pw; upd_at_top = ut; om_mode = m;
    force_cmp = f; flag_clr = fc;
    #1;
    vis = visible(pw);
    chk(pw ? "R5 read" : "R4 read", {8'h00, rd_data}, {8'h00, rh ? vis[15:8] : vis[7:0]});
    hitm = (c == m_act);
    chk("R6 match_pulse", {15'd0, match_pulse}, {15'd0, hitm});
    chk("R7 flag", {15'd0, match_flag}, {15'd0, m_flag});
    chk("R8 pin", {15'd0, oc_pin}, {15'd0, m_pin});
    nstage = (we && hi) ? d : m_stage;
    nshad  = m_shad;
    nact   = m_act;
    if (pw) begin
      if (we && !hi) nshad = {m_stage, d};
      if (ut ? t : b) nact = m_shad;
    end else if (we && !hi) begin
      nact = {m_stage, d};
    end
    nflag = hitm ? 1'b1 : (m_flag & ~fc);
    npin  = pin_after(m_pin, hitm | (f & ~pw), m);
    @(posedge clk);
    @(negedge clk);
    m_stage = nstage; m_shad = nshad; m_act = nact; m_flag = nflag; m_pin = npin;
  endtask

  task automatic probe(bit rh, output logic [7:0] v);
    rd_hi = rh;
    #1;
    v = rd_data;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    wr_en = 0; wr_hi = 0; wr_data = 0; rd_hi = 0; cnt = 16'h0001; at_top = 0;
    at_bottom = 0; pwm_mode = 0; upd_at_top = 0; om_mode = 0; force_cmp = 0; flag_clr = 0;
    m_stage = 0; m_shad = 0; m_act = 0; m_flag = 0; m_pin = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 flag", {15'd0, match_flag}, 16'd0);
    chk("R1 pin", {15'd0, oc_pin}, 16'd0);
    probe(1, v); chk("R1 read hi", {8'd0, v}, 16'd0);
    probe(0, v); chk("R1 read lo", {8'd0, v}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: high write only stages
    step(1, 1, 8'hAB, 0, 16'h0001, 0, 0, 0, 0, 2'b00, 0, 0);
    probe(1, v); chk("R2 read hi unchanged", {8'd0, v}, 16'h0000);
    probe(0, v); chk("R2 read lo unchanged", {8'd0, v}, 16'h0000);
    // R3: low write joins staging; staging retained
    step(1, 0, 8'hCD, 0, 16'h0001, 0, 0, 0, 0, 2'b00, 0, 0);
    probe(1, v); chk("R3 read hi", {8'd0, v}, 16'h00AB);
    probe(0, v); chk("R3 read lo", {8'd0, v}, 16'h00CD);
    step(1, 0, 8'h11, 0, 16'h0001, 0, 0, 0, 0, 2'b00, 0, 0);
    probe(1, v); chk("R3 staging reused", {8'd0, v}, 16'h00AB);
    // R4: direct compare of new value
    step(0, 0, 0, 0, 16'hAB11, 0, 0, 0, 0, 2'b00, 0, 1);
    chk("R4 flag after match", {15'd0, match_flag}, 16'd1);

    // R5: buffered write, update only on selected strobe (TOP)
    step(1, 1, 8'h12, 0, 16'h0001, 0, 0, 1, 1, 2'b00, 0, 1);
    step(1, 0, 8'h34, 0, 16'h0001, 0, 0, 1, 1, 2'b00, 0, 0);
    probe(1, v); chk("R5 shadow hi", {8'd0, v}, 16'h0012);
    probe(0, v); chk("R5 shadow lo", {8'd0, v}, 16'h0034);
    step(0, 0, 0, 0, 16'h0001, 0, 1, 1, 1, 2'b00, 0, 0);
    cnt = 16'hAB11; #1;
    chk("R5 active held after unselected strobe", {15'd0, match_pulse}, 16'd1);
    step(0, 0, 0, 0, 16'h0001, 1, 0, 1, 1, 2'b00, 0, 0);
    cnt = 16'h1234; #1;
    chk("R5 active updated at TOP", {15'd0, match_pulse}, 16'd1);

    // R10: force ignored in PWM
    step(0, 0, 0, 0, 16'h0001, 0, 0, 1, 1, 2'b11, 1, 1);
    chk("R10 pin unchanged", {15'd0, oc_pin}, 16'd0);
    // R9: force in non-PWM sets pin, no flag
    step(0, 0, 0, 0, 16'h0001, 0, 0, 0, 0, 2'b11, 1, 0);
    chk("R9 pin set by force", {15'd0, oc_pin}, 16'd1);
    chk("R9 flag untouched", {15'd0, match_flag}, 16'd0);
    step(0, 0, 0, 0, 16'h0001, 0, 0, 0, 0, 2'b01, 1, 0);
    chk("R9 toggle by force", {15'd0, oc_pin}, 16'd0);
    // R7: set wins over clear
    step(0, 0, 0, 0, 16'h1234, 0, 0, 0, 0, 2'b10, 0, 1);
    chk("R7 set wins", {15'd0, match_flag}, 16'd1);
    // R8: clear mode on match
    step(0, 0, 0, 0, 16'h0001, 0, 0, 0, 0, 2'b11, 1, 0);
    step(0, 0, 0, 0, 16'h1234, 0, 0, 0, 0, 2'b10, 0, 0);
    chk("R8 clear on match", {15'd0, oc_pin}, 16'd0);

    // random phase
    begin
      bit pw;
      pw = 0;
      for (int i = 0; i < 4000; i++) begin
        logic [15:0] c;
        if (($urandom % 60) == 0) pw = ~pw;
        case ($urandom % 4)
          0: c = m_act;
          1: c = m_shad;
          default: c = 16'($urandom);
        endcase
        step(($urandom % 3) == 0, $urandom % 2, 8'($urandom), $urandom % 2, c,
             ($urandom % 6) == 0, ($urandom % 6) == 0, pw, $urandom % 2,
             2'($urandom), ($urandom % 6) == 0, ($urandom % 6) == 0);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule